// File: doc/BRIEF.md
# Cartridge Bank Controller with 9-bit ROM Bank

This block sits between an 8-bit CPU bus with a 16-bit address and the external ROM and RAM arrays of a cartridge. It watches CPU writes into the ROM address space and uses them to load four control registers. These registers hold a RAM gate, the low eight bits of the ROM bank, the top bit of the ROM bank, and a 4-bit RAM bank. CPU reads and writes that land in the cartridge windows are translated into physical array addresses. The block emits one registered request per access.

The low 16 KB window always shows ROM bank 0. The upper 16 KB ROM window shows the selected bank, and any of 512 banks may be chosen, bank 0 included. The 8 KB RAM window shows one of 16 banks. An access is suppressed when RAM is gated off, or when the physical offset falls at or past the configured array size. A suppressed read raises a blank flag, and the bus side then returns 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM is gated off, and every output is 0. A read at 0x4000 then gives rom_addr 0x4000, and a read at 0xA000 gives rd_blank.
- R2: A write anywhere in 0x0000–0x1FFF turns RAM on when data bits 3:0 equal 0xA. Any other value turns it off.
- R3: A write in 0x2000–0x2FFF loads ROM bank bits 7:0 from the data byte and leaves bank bit 8 unchanged.
- R4: A write in 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R5: A ROM bank value of 0 is used exactly as written in the switchable window, with no substitution.
- R6: A write in 0x4000–0x5FFF loads the RAM bank from data bits 3:0. Data bits 7:4 are ignored.
- R7: A read in 0x0000–0x3FFF addresses the offset address[13:0] of bank 0. A read in 0x4000–0x7FFF addresses bank × 0x4000 + address[13:0].
- R8: An access in 0xA000–0xBFFF addresses RAM bank × 0x2000 + address[12:0]. A write carries its data byte on ram_wdata.
- R9: A ROM read whose physical address is at or above ROM_SIZE asserts rd_blank instead of rom_rd.
- R10: A RAM access is suppressed when RAM is off or when the physical address is at or above RAM_SIZE. A suppressed read asserts rd_blank, and a suppressed write raises no strobe.
- R11: Outputs appear in the cycle after the request, with at most one of rom_rd, ram_rd and ram_wr set. Control-register writes and accesses outside the cartridge windows raise no strobe and no rd_blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request (wins over cpu_rd) |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_rd | output | 1 | ROM read strobe |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| rd_blank | output | 1 | Read suppressed, bus returns 0xFF |

## Verification
The assertions run on every cycle. They check that the strobes are mutually exclusive and that no strobe ever carries an address past the configured array size. They also check that control writes stay silent, that the fixed window maps to bank 0, and that rd_blank never comes with a read strobe. Some behaviour depends on the history of register writes, and only the bench scenarios can show it. This covers the split-bank merge (which bits are kept on each write), bank 0 used as written, the RAM gate nibble decode, and the exact bank arithmetic. The bench covers these by sweeping all 512 ROM banks, all 16 RAM banks and all 256 gate values.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    WIN_FIXED,
    WIN_BANKED,
    WIN_RAM,
    WIN_NONE
  } win_e;

  typedef enum logic [2:0] {
    CTL_RAM_GATE,
    CTL_ROM_LO,
    CTL_ROM_HI,
    CTL_RAM_BANK,
    CTL_NONE
  } ctl_e;

  function automatic win_e win_of(input logic [15:0] a);
    if (a[15:14] == 2'b00)      return WIN_FIXED;
    else if (a[15:14] == 2'b01) return WIN_BANKED;
    else if (a[15:13] == 3'b101) return WIN_RAM;
    else                        return WIN_NONE;
  endfunction

  function automatic ctl_e ctl_of(input logic [15:0] a);
    case (a[15:12])
      4'h0, 4'h1: return CTL_RAM_GATE;
      4'h2:       return CTL_ROM_LO;
      4'h3:       return CTL_ROM_HI;
      4'h4, 4'h5: return CTL_RAM_BANK;
      default:    return CTL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [15:0]           addr,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_on
);
  localparam int HI_W = ROM_BANK_W - 8;
  localparam logic [ROM_BANK_W-1:0] ROM_BANK_RST = ROM_BANK_W'(1);

  ctl_e sel;
  assign sel = ctl_of(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= ROM_BANK_RST;
      ram_bank <= '0;
      ram_on   <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        CTL_RAM_GATE: ram_on <= (wdata[3:0] == 4'hA);
        CTL_ROM_LO:   rom_bank[7:0] <= wdata;
        CTL_ROM_HI:   rom_bank[ROM_BANK_W-1:8] <= wdata[HI_W-1:0];
        CTL_RAM_BANK: ram_bank <= wdata[RAM_BANK_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_WIN_W  = 14,
  parameter int RAM_WIN_W  = 13,
  parameter int ROM_SIZE   = 1 << 21,
  parameter int RAM_SIZE   = 1 << 15,
  localparam int ROM_AW    = ROM_BANK_W + ROM_WIN_W,
  localparam int RAM_AW    = RAM_BANK_W + RAM_WIN_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           addr,
  input  logic [7:0]            wdata,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  ram_on,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_rd,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_rd,
  output logic                  ram_wr,
  output logic [7:0]            ram_wdata,
  output logic                  rd_blank
);
  localparam logic [ROM_AW:0] ROM_LIM = (ROM_AW + 1)'(ROM_SIZE);
  localparam logic [RAM_AW:0] RAM_LIM = (RAM_AW + 1)'(RAM_SIZE);

  win_e                  win;
  logic [ROM_BANK_W-1:0] rom_bank_eff;
  logic [ROM_AW-1:0]     rom_phys;
  logic [RAM_AW-1:0]     ram_phys;
  logic                  rom_ok;
  logic                  ram_ok;

  always_comb begin
    win          = win_of(addr);
    rom_bank_eff = (win == WIN_FIXED) ? '0 : rom_bank;
    rom_phys     = {rom_bank_eff, addr[ROM_WIN_W-1:0]};
    ram_phys     = {ram_bank, addr[RAM_WIN_W-1:0]};
    rom_ok       = ({1'b0, rom_phys} < ROM_LIM);
    ram_ok       = ram_on && ({1'b0, ram_phys} < RAM_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_rd    <= 1'b0;
      ram_addr  <= '0;
      ram_rd    <= 1'b0;
      ram_wr    <= 1'b0;
      ram_wdata <= '0;
      rd_blank  <= 1'b0;
    end else begin
      rom_rd   <= 1'b0;
      ram_rd   <= 1'b0;
      ram_wr   <= 1'b0;
      rd_blank <= 1'b0;
      if (wr) begin
        if (win == WIN_RAM) begin
          ram_addr  <= ram_phys;
          ram_wdata <= wdata;
          ram_wr    <= ram_ok;
        end
      end else if (rd) begin
        case (win)
          WIN_FIXED, WIN_BANKED: begin
            rom_addr <= rom_phys;
            rom_rd   <= rom_ok;
            rd_blank <= !rom_ok;
          end
          WIN_RAM: begin
            ram_addr <= ram_phys;
            ram_rd   <= ram_ok;
            rd_blank <= !ram_ok;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_WIN_W  = 14,
  parameter int RAM_WIN_W  = 13,
  parameter int ROM_SIZE   = 1 << 21,
  parameter int RAM_SIZE   = 1 << 15,
  localparam int ROM_AW    = ROM_BANK_W + ROM_WIN_W,
  localparam int RAM_AW    = RAM_BANK_W + RAM_WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [7:0]        ram_wdata,
  output logic              rd_blank
);
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_on;

  cbc_regs #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr),
    .addr    (cpu_addr),
    .wdata   (cpu_wdata),
    .rom_bank(rom_bank),
    .ram_bank(ram_bank),
    .ram_on  (ram_on)
  );

  cbc_xlate #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W),
    .ROM_WIN_W (ROM_WIN_W),
    .RAM_WIN_W (RAM_WIN_W),
    .ROM_SIZE  (ROM_SIZE),
    .RAM_SIZE  (RAM_SIZE)
  ) u_xlate (
    .clk      (clk),
    .rst      (rst),
    .addr     (cpu_addr),
    .wdata    (cpu_wdata),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_on   (ram_on),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd),
    .ram_addr (ram_addr),
    .ram_rd   (ram_rd),
    .ram_wr   (ram_wr),
    .ram_wdata(ram_wdata),
    .rd_blank (rd_blank)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_AW    = 23,
  parameter int RAM_AW    = 17,
  parameter int ROM_WIN_W = 14,
  parameter int ROM_SIZE  = 1 << 21,
  parameter int RAM_SIZE  = 1 << 15
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_rd,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_rd,
  input logic              ram_wr,
  input logic              rd_blank
);
  localparam logic [ROM_AW:0] ROM_LIM = (ROM_AW + 1)'(ROM_SIZE);
  localparam logic [RAM_AW:0] RAM_LIM = (RAM_AW + 1)'(RAM_SIZE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_rd, ram_rd, ram_wr})); // R11

  AST_ROM_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> ({1'b0, rom_addr} < ROM_LIM)); // R9

  AST_RAM_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (ram_rd || ram_wr) |-> ({1'b0, ram_addr} < RAM_LIM)); // R10

  AST_BLANK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    rd_blank |-> !(rom_rd || ram_rd || ram_wr)); // R10

  AST_CTRL_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[15]) |=> !(rom_rd || ram_rd || ram_wr || rd_blank)); // R11

  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b00)
      |=> (rom_rd && rom_addr == {{(ROM_AW-ROM_WIN_W){1'b0}}, $past(cpu_addr[ROM_WIN_W-1:0])})); // R7

endmodule

bind cart_bank_ctrl cbc_checker #(
  .ROM_AW   (ROM_AW),
  .RAM_AW   (RAM_AW),
  .ROM_WIN_W(ROM_WIN_W),
  .ROM_SIZE (ROM_SIZE),
  .RAM_SIZE (RAM_SIZE)
) u_cbc_checker (
  .clk     (clk),
  .rst     (rst),
  .cpu_addr(cpu_addr),
  .cpu_rd  (cpu_rd),
  .cpu_wr  (cpu_wr),
  .rom_addr(rom_addr),
  .rom_rd  (rom_rd),
  .ram_addr(ram_addr),
  .ram_rd  (ram_rd),
  .ram_wr  (ram_wr),
  .rd_blank(rd_blank)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  localparam int ROM_SIZE = 1 << 21;
  localparam int RAM_SIZE = 1 << 15;
  localparam int ROM_AW   = 23;
  localparam int RAM_AW   = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_rd = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_rd;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_rd;
  logic              ram_wr;
  logic [7:0]        ram_wdata;
  logic              rd_blank;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_SIZE(ROM_SIZE), .RAM_SIZE(RAM_SIZE)) u_cart_bank_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_wdata(ram_wdata), .rd_blank(rd_blank)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Drive one request at a falling edge; outputs are valid at the next falling edge.
  task automatic access(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic quiet(input string tag);
    chk(tag, {rom_rd, ram_rd, ram_wr, rd_blank}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs idle after reset", {rom_rd, ram_rd, ram_wr, rd_blank}, 0);

    // R1: default bank 1 and RAM off
    access(1'b0, 1'b1, 16'h4000, 8'h00);
    chk("R1 rom_rd", rom_rd, 1);
    chk("R1 rom_addr bank1", rom_addr, 32'h4000);
    access(1'b0, 1'b1, 16'hA000, 8'h00);
    chk("R1 ram off blank", rd_blank, 1);
    chk("R1 ram off no rd", ram_rd, 0);

    // R11: outside windows and control writes stay silent
    access(1'b0, 1'b1, 16'h8123, 8'h00);
    quiet("R11 read 0x8123");
    access(1'b0, 1'b1, 16'hC000, 8'h00);
    quiet("R11 read 0xC000");
    access(1'b1, 1'b0, 16'h2000, 8'h05);
    quiet("R11 ctrl write");

    // R7: fixed window ignores the selected bank (5)
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = 16'((i * 1031 + 3) & 16'h3FFF);
      access(1'b0, 1'b1, a, 8'h00);
      chk("R7 fixed rd", rom_rd, 1);
      chk("R7 fixed addr", rom_addr, {16'h0, a});
    end

    // R3 R5 R7 R9: sweep all ROM banks, high bit first then low byte
    for (int b = 0; b < 512; b++) begin
      int off, phys;
      bit ok;
      off = (b * 97 + 5) & 16'h3FFF;
      access(1'b1, 1'b0, 16'h3ABC, {7'b1010101, b[8]});
      access(1'b1, 1'b0, 16'h2F00, b[7:0]);
      access(1'b0, 1'b1, 16'(16'h4000 | off), 8'h00);
      phys = b * 16384 + off;
      ok = (phys < ROM_SIZE);
      chk("R3 R9 rom_rd", rom_rd, ok);
      chk("R9 rd_blank", rd_blank, !ok);
      if (ok) chk("R5 R7 banked addr", rom_addr, phys);
    end

    // R4: high bit write keeps low byte
    access(1'b1, 1'b0, 16'h2000, 8'h34);
    access(1'b1, 1'b0, 16'h3000, 8'h03);
    access(1'b0, 1'b1, 16'h4000, 8'h00);
    chk("R4 bank 0x134 out of range", rd_blank, 1);
    access(1'b1, 1'b0, 16'h3FFF, 8'hFE);
    access(1'b0, 1'b1, 16'h4001, 8'h00);
    chk("R4 bank 0x034 rd", rom_rd, 1);
    chk("R4 bank 0x034 addr", rom_addr, 32'h34 * 16384 + 1);

    // R6 R8 R10: RAM on, sweep all RAM banks with junk in data bits 7:4
    access(1'b1, 1'b0, 16'h0800, 8'h3A);
    for (int k = 0; k < 16; k++) begin
      int off, phys;
      bit ok;
      off = (k * 301 + 7) & 16'h1FFF;
      phys = k * 8192 + off;
      ok = (phys < RAM_SIZE);
      access(1'b1, 1'b0, 16'h4000 + 16'(k * 16'h0100), {4'hC, 4'(k)});
      access(1'b1, 1'b0, 16'(16'hA000 | off), 8'(k + 8'h40));
      chk("R10 ram_wr", ram_wr, ok);
      if (ok) begin
        chk("R6 R8 wr addr", ram_addr, phys);
        chk("R8 wdata", ram_wdata, k + 8'h40);
      end
      access(1'b0, 1'b1, 16'(16'hA000 | off), 8'h00);
      chk("R10 ram_rd", ram_rd, ok);
      chk("R10 blank", rd_blank, !ok);
      if (ok) chk("R8 rd addr", ram_addr, phys);
    end

    // R2: gate nibble sweep over all data values, bank 0
    access(1'b1, 1'b0, 16'h5000, 8'h00);
    for (int v = 0; v < 256; v++) begin
      bit on;
      on = (v[3:0] == 4'hA);
      access(1'b1, 1'b0, 16'(v * 32), 8'(v));
      access(1'b0, 1'b1, 16'hA004, 8'h00);
      chk("R2 gate ram_rd", ram_rd, on);
      chk("R2 gate blank", rd_blank, !on);
    end
    // Gate is now off (last value 0xFF): write suppressed
    access(1'b1, 1'b0, 16'hA004, 8'h99);
    chk("R10 write while off", ram_wr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule